// File: doc/BRIEF.md
# Bus-Attached Serial Port with Status and Control Registers

This block is a peripheral-bus slave that owns one asynchronous serial line pair. Software places a byte on the line by writing the data register. It learns about arriving bytes by polling a status word, or by taking a one-cycle interrupt pulse. A control word enables the receiver, the transmitter, the two interrupt sources and an internal loopback path. Characters are always eight data bits, least significant bit first, with one start bit, one stop bit and no parity. Every bit lasts `CLKS_PER_BIT` clock cycles.

The receive side keeps one holding register and no queue. A byte that completes while the previous byte is still unread raises an overrun flag, and the held byte is kept. Reading the data register returns the held byte and clears the ready flag and the line-error flags. The register window spans 20 bytes. Three offsets are decoded: data at 0x00, status at 0x04 and control at 0x08. Offsets 0x0C and 0x10 are reserved; they read as zero and ignore writes.

The transmitter is a four-state machine: `TX_IDLE`, `TX_START`, `TX_DATA` and `TX_STOP`. It moves from `TX_IDLE` to `TX_START` on an accepted data write. Each later state advances when its bit time ends, and `TX_DATA` repeats until eight bits have gone out. The receiver uses the same four state names with an `RX_` prefix. It moves from `RX_IDLE` to `RX_START` on a falling line edge. It goes back to `RX_IDLE` if the line is high again at mid start bit. Otherwise it samples each data bit at mid bit, samples the stop bit in `RX_STOP`, and then returns to `RX_IDLE`.

Top module: `apb_uart`

## Requirements
- R1: After reset the status register reads 0x00000006, the control register reads 0, `irq` is 0 and `txd` is 1.
- R2: A write to offset 0x00, with transmit enable (control bit 1) set and the transmitter idle, sends `pwdata[7:0]` on `txd` as one frame. The frame is a low start bit, eight data bits LSB first and a high stop bit, each lasting `CLKS_PER_BIT` cycles. `pwdata[31:8]` is ignored.
- R3: Status bit 1 (transmit shift empty) and status bit 2 (transmit buffer empty) fall on the clock edge that completes an accepted data write, and rise again after the stop bit. A data write is dropped if it is made while a frame is being sent or while control bit 1 is 0.
- R4: With receive enable (control bit 0) set, a received frame stores its byte and sets status bit 0 (data ready). A read of offset 0x00 returns the byte in bits 7:0, with zeros above, and clears status bit 0.
- R5: When a byte is received with receive interrupt enable (control bit 2) set, `irq` is high for exactly one clock cycle. With control bit 2 clear, no pulse is produced.
- R6: A byte that completes while status bit 0 is set sets status bit 4 (overrun) and leaves the held byte unchanged. Writing a 0 to status bit 4 clears it. Writing a 1 to bit 4 has no effect, and no other status bit can be written.
- R7: A frame whose stop bit is sampled low sets status bit 6 (framing error). If all of its data bits are also 0, it sets status bit 3 (break) as well. A read of offset 0x00 clears both bits.
- R8: While control bit 0 is 0, frames on `rxd` are ignored and status bit 0 stays 0.
- R9: With loopback (control bit 7) set, the receiver takes its input from the transmitter output and ignores `rxd`. `txd` still carries the frame.
- R10: Control bits 0, 1, 2, 3 and 7 read back as written. All other control bits read 0, bit 31 included. Status bits 5 and 7 to 31 always read 0.
- R11: Writes to offsets 0x0C, 0x10 and other undecoded offsets change nothing and send nothing. Reads of those offsets return 0.
- R12: With transmit interrupt enable (control bit 3) set, `irq` pulses for one cycle when a frame's stop bit ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected for a read |
| irq | output | 1 | One-cycle interrupt pulse |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |

## Verification
The checker assumes three things about the bus:
- Every transfer is a two-cycle access: a setup cycle with `psel` high, then an access cycle with `penable` high.
- `paddr` and `pwdata` stay stable across both cycles.
- `rxd` only changes on whole bit times, so mid-bit sampling sees a settled level.

The bench drives every access through one task that keeps this ordering, and it changes inputs only on falling clock edges. The serial driver holds each level for exactly `CLKS_PER_BIT` cycles and returns the line high between frames. That way a framing-error frame never leaves a stray falling edge that the receiver could take for a new start bit.

// File: rtl/apb_uart_pkg.sv
package apb_uart_pkg;

    localparam int DATA_W   = 8;
    localparam int REG_W    = 32;

    localparam int OFS_DATA = 'h00;
    localparam int OFS_STAT = 'h04;
    localparam int OFS_CTRL = 'h08;

    // status bit positions
    localparam int ST_RDY   = 0;
    localparam int ST_TSE   = 1;
    localparam int ST_TBE   = 2;
    localparam int ST_BRK   = 3;
    localparam int ST_OVR   = 4;
    localparam int ST_FRM   = 6;

    // control bit positions
    localparam int CT_RXEN  = 0;
    localparam int CT_TXEN  = 1;
    localparam int CT_RXIE  = 2;
    localparam int CT_TXIE  = 3;
    localparam int CT_LOOP  = 7;

    localparam logic [REG_W-1:0] CTRL_MASK =
        REG_W'((1 << CT_RXEN) | (1 << CT_TXEN) | (1 << CT_RXIE) |
               (1 << CT_TXIE) | (1 << CT_LOOP));

    typedef enum logic [1:0] {
        TX_IDLE, TX_START, TX_DATA, TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP
    } rx_state_e;

endpackage

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import apb_uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              done,
    output logic              txd
);
    localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic              bit_end;

    assign bit_end = (cnt_q == LAST_CNT);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        sh_d    = sh_q;
        unique case (state_q)
            TX_IDLE: begin
                if (go) begin
                    state_d = TX_START;
                    cnt_d   = '0;
                    sh_d    = din;
                end
            end
            TX_START: begin
                if (bit_end) begin
                    state_d = TX_DATA;
                    cnt_d   = '0;
                    idx_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            TX_DATA: begin
                if (bit_end) begin
                    cnt_d = '0;
                    sh_d  = sh_q >> 1;
                    if (idx_q == LAST_IDX) begin
                        state_d = TX_STOP;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            TX_STOP: begin
                if (bit_end) begin
                    state_d = TX_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            sh_q    <= sh_d;
        end
    end

    always_comb begin
        txd  = 1'b1;
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            TX_IDLE:  busy = 1'b0;
            TX_START: txd  = 1'b0;
            TX_DATA:  txd  = sh_q[0];
            TX_STOP:  done = bit_end;
        endcase
    end

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import apb_uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              line,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              frame_err
);
    localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(CLKS_PER_BIT / 2 - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic              line_q;
    logic              bit_end;

    assign bit_end = (cnt_q == LAST_CNT);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        sh_d    = sh_q;
        unique case (state_q)
            RX_IDLE: begin
                if (line_q && !line) begin
                    state_d = RX_START;
                    cnt_d   = '0;
                end
            end
            RX_START: begin
                if (cnt_q == HALF_CNT) begin
                    cnt_d   = '0;
                    idx_d   = '0;
                    state_d = line ? RX_IDLE : RX_DATA;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            RX_DATA: begin
                if (bit_end) begin
                    cnt_d = '0;
                    sh_d  = {line, sh_q[DATA_W-1:1]};
                    if (idx_q == LAST_IDX) begin
                        state_d = RX_STOP;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            RX_STOP: begin
                if (bit_end) begin
                    state_d = RX_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
        if (!en) begin
            state_d = RX_IDLE;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            line_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            sh_q    <= sh_d;
            line_q  <= line;
        end
    end

    always_comb begin
        valid     = 1'b0;
        frame_err = 1'b0;
        data      = sh_q;
        unique case (state_q)
            RX_IDLE, RX_START, RX_DATA: valid = 1'b0;
            RX_STOP: begin
                valid     = bit_end && en;
                frame_err = !line;
            end
        endcase
    end

endmodule

// File: rtl/uart_regs.sv
module uart_regs
    import apb_uart_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [REG_W-1:0]  pwdata,
    output logic [REG_W-1:0]  prdata,
    output logic              irq,
    input  logic              tx_busy,
    input  logic              tx_done,
    output logic              tx_go,
    output logic [DATA_W-1:0] tx_din,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_ferr,
    output logic [REG_W-1:0]  ctrl_o,
    output logic [REG_W-1:0]  stat_o,
    output logic [DATA_W-1:0] hold_o
);
    logic [REG_W-1:0]  ctrl_q;
    logic [DATA_W-1:0] hold_q;
    logic              rdy_q, ovr_q, frm_q, brk_q, irq_q;
    logic              wr_acc, rd_acc, hit_data, hit_stat, hit_ctrl, rd_clr;

    assign wr_acc   = psel && penable && pwrite;
    assign rd_acc   = psel && penable && !pwrite;
    assign hit_data = (paddr == ADDR_W'(OFS_DATA));
    assign hit_stat = (paddr == ADDR_W'(OFS_STAT));
    assign hit_ctrl = (paddr == ADDR_W'(OFS_CTRL));
    assign rd_clr   = rd_acc && hit_data;
    assign tx_go    = wr_acc && hit_data && ctrl_q[CT_TXEN] && !tx_busy;
    assign tx_din   = pwdata[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            hold_q <= '0;
            rdy_q  <= 1'b0;
            ovr_q  <= 1'b0;
            frm_q  <= 1'b0;
            brk_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_acc && hit_ctrl) begin
                ctrl_q <= pwdata & CTRL_MASK;
            end
            if (rd_clr) begin
                rdy_q <= 1'b0;
                frm_q <= 1'b0;
                brk_q <= 1'b0;
            end
            if (wr_acc && hit_stat && !pwdata[ST_OVR]) begin
                ovr_q <= 1'b0;
            end
            if (rx_valid) begin
                if (rdy_q && !rd_clr) begin
                    ovr_q <= 1'b1;
                end else begin
                    hold_q <= rx_data;
                    rdy_q  <= 1'b1;
                    frm_q  <= rx_ferr;
                    brk_q  <= rx_ferr && (rx_data == '0);
                end
            end
            irq_q <= (rx_valid && ctrl_q[CT_RXIE]) ||
                     (tx_done && ctrl_q[CT_TXIE]);
        end
    end

    always_comb begin
        stat_o         = '0;
        stat_o[ST_RDY] = rdy_q;
        stat_o[ST_TSE] = !tx_busy;
        stat_o[ST_TBE] = !tx_busy;
        stat_o[ST_BRK] = brk_q;
        stat_o[ST_OVR] = ovr_q;
        stat_o[ST_FRM] = frm_q;
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (hit_data) begin
                prdata = {{(REG_W-DATA_W){1'b0}}, hold_q};
            end else if (hit_stat) begin
                prdata = stat_o;
            end else if (hit_ctrl) begin
                prdata = ctrl_q;
            end
        end
    end

    assign irq    = irq_q;
    assign ctrl_o = ctrl_q;
    assign hold_o = hold_q;

endmodule

// File: rtl/apb_uart.sv
module apb_uart
    import apb_uart_pkg::*;
#(
    parameter int ADDR_W       = 5,
    parameter int CLKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [REG_W-1:0]  pwdata,
    output logic [REG_W-1:0]  prdata,
    output logic              irq,
    output logic              txd,
    input  logic              rxd
);
    logic              tx_go, tx_busy, tx_done, tx_line;
    logic [DATA_W-1:0] tx_din;
    logic              rx_valid, rx_ferr;
    logic [DATA_W-1:0] rx_data;
    logic [REG_W-1:0]  ctrl, stat;
    logic [DATA_W-1:0] hold;
    logic [1:0]        sync_q;
    logic              rx_src;

    assign rx_src = ctrl[CT_LOOP] ? tx_line : rxd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], rx_src};
        end
    end

    uart_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .irq      (irq),
        .tx_busy  (tx_busy),
        .tx_done  (tx_done),
        .tx_go    (tx_go),
        .tx_din   (tx_din),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ferr  (rx_ferr),
        .ctrl_o   (ctrl),
        .stat_o   (stat),
        .hold_o   (hold)
    );

    uart_tx_fsm #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (tx_go),
        .din   (tx_din),
        .busy  (tx_busy),
        .done  (tx_done),
        .txd   (tx_line)
    );

    uart_rx_fsm #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl[CT_RXEN]),
        .line      (sync_q[1]),
        .valid     (rx_valid),
        .data      (rx_data),
        .frame_err (rx_ferr)
    );

    assign txd = tx_line;

endmodule

// File: rtl/apb_uart_chk.sv
module apb_uart_chk
    import apb_uart_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [REG_W-1:0]  prdata,
    input logic              irq,
    input logic              txd,
    input logic              tx_go,
    input logic              tx_done,
    input logic              rx_valid,
    input logic [REG_W-1:0]  ctrl,
    input logic [REG_W-1:0]  stat,
    input logic [DATA_W-1:0] hold
);
    logic data_rd;
    assign data_rd = psel && penable && !pwrite && (paddr == ADDR_W'(OFS_DATA));

    // R5
    rx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && ctrl[CT_RXIE] |=> irq);

    // R12
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((rx_valid && ctrl[CT_RXIE]) || (tx_done && ctrl[CT_TXIE])));

    // R3
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |=> !txd && !stat[ST_TSE]);

    // R2
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[ST_TSE] |-> txd);

    // R4
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> stat[ST_RDY]);

    // R6
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && stat[ST_RDY] && !data_rd |=> $stable(hold) && stat[ST_OVR]);

    // R11
    hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !pwrite && (paddr == ADDR_W'('h0C) || paddr == ADDR_W'('h10))
        |-> prdata == '0);

endmodule

bind apb_uart apb_uart_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .prdata   (prdata),
    .irq      (irq),
    .txd      (txd),
    .tx_go    (tx_go),
    .tx_done  (tx_done),
    .rx_valid (rx_valid),
    .ctrl     (ctrl),
    .stat     (stat),
    .hold     (hold)
);

// File: tb/test_apb_uart.sv
`timescale 1ns/1ps
module test_apb_uart;
    localparam int AW  = 5;
    localparam int CPB = 8;
    localparam int FRAME_WAIT = 11 * CPB + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic irq, txd;
    logic rxd = 1'b1;

    int checks = 0;
    int errors = 0;
    int tx_count = 0;
    logic [7:0] tx_last = '0;
    int irq_cnt = 0;
    int irq_wide = 0;
    logic irq_q = 1'b0;
    bit finished = 0;

    always #4 clk = ~clk;

    apb_uart #(.ADDR_W(AW), .CLKS_PER_BIT(CPB)) i_apb_uart (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .irq(irq), .txd(txd), .rxd(rxd)
    );

    // stimulus: vectors carry junk in the upper bits, low byte is the character
    localparam logic [31:0] VEC [6] = '{
        32'hDEAD_BE55, 32'h0000_00A3, 32'hFFFF_FF00,
        32'h1234_56FF, 32'h8000_0001, 32'h0F0F_0F80
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rxd = 1'b0;
        wait_cycles(CPB);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_cycles(CPB);
        end
        rxd = stop;
        wait_cycles(CPB);
        rxd = 1'b1;
        wait_cycles(2 * CPB);
    endtask

    // serial line monitor on txd
    initial begin
        logic [7:0] b;
        forever begin
            @(negedge clk);
            if (rst_n && txd == 1'b0) begin
                wait_cycles(CPB / 2);
                for (int i = 0; i < 8; i++) begin
                    wait_cycles(CPB);
                    b[i] = txd;
                end
                wait_cycles(CPB);
                if (txd !== 1'b1) begin
                    errors++; checks++;
                    $display("FAIL R2 stop bit actual=%b expected=1", txd);
                end
                tx_last = b;
                tx_count++;
            end
        end
    end

    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (irq && irq_q) irq_wide++;
        irq_q <= irq;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int c0, i0;
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(2);

        // R1 reset state
        bus_rd(5'h04, r); check("R1 status", r, 32'h6);
        bus_rd(5'h08, r); check("R1 control", r, 32'h0);
        check("R1 txd", {31'b0, txd}, 32'h1);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R10 control readback mask
        bus_wr(5'h08, 32'hFFFF_FFFF);
        bus_rd(5'h08, r); check("R10 control mask", r, 32'h8F);
        bus_rd(5'h04, r); check("R10 status zeros", r & 32'hFFFF_FFA0, 32'h0);

        // vector table, loopback with receive interrupt
        bus_wr(5'h08, 32'h87);
        for (int i = 0; i < 6; i++) begin
            c0 = tx_count; i0 = irq_cnt;
            bus_wr(5'h00, VEC[i]);
            bus_rd(5'h04, r); check("R3 busy after write", r & 32'h6, 32'h0);
            wait_cycles(FRAME_WAIT);
            bus_rd(5'h04, r); check("R4 ready set", r, 32'h7);
            bus_rd(5'h00, r); check("R4 data read", r, {24'h0, VEC[i][7:0]});
            bus_rd(5'h04, r); check("R4 ready cleared", r, 32'h6);
            check("R2 line byte", {24'h0, tx_last}, {24'h0, VEC[i][7:0]});
            check("R2 frame count", tx_count, c0 + 1);
            check("R5 one pulse", irq_cnt, i0 + 1);
        end
        check("R5 pulse width", irq_wide, 0);

        // R12 transmit interrupt, receiver off
        bus_wr(5'h08, 32'h0A);
        i0 = irq_cnt;
        bus_wr(5'h00, 32'h3E);
        wait_cycles(FRAME_WAIT);
        check("R12 tx pulse", irq_cnt, i0 + 1);

        // R3 write while busy dropped
        bus_wr(5'h08, 32'h02);
        c0 = tx_count;
        bus_wr(5'h00, 32'h11);
        bus_wr(5'h00, 32'h22);
        wait_cycles(FRAME_WAIT);
        check("R3 busy drop count", tx_count, c0 + 1);
        check("R3 busy drop byte", {24'h0, tx_last}, 32'h11);
        bus_rd(5'h04, r); check("R3 idle again", r & 32'h6, 32'h6);

        // R3 transmitter disabled
        bus_wr(5'h08, 32'h00);
        bus_wr(5'h00, 32'h33);
        bus_rd(5'h04, r); check("R3 disabled stays empty", r & 32'h6, 32'h6);
        wait_cycles(FRAME_WAIT);
        check("R3 disabled no frame", tx_count, c0 + 1);

        // R6 overrun, R5 no pulse with interrupt off
        bus_wr(5'h08, 32'h83);
        i0 = irq_cnt;
        bus_wr(5'h00, 32'h5A);
        wait_cycles(FRAME_WAIT);
        bus_wr(5'h00, 32'hC3);
        wait_cycles(FRAME_WAIT);
        check("R5 no pulse when disabled", irq_cnt, i0);
        bus_rd(5'h04, r); check("R6 overrun set", r, 32'h17);
        bus_rd(5'h00, r); check("R6 first byte kept", r, 32'h5A);
        bus_rd(5'h04, r); check("R6 overrun sticky", r, 32'h16);
        bus_wr(5'h04, 32'hFFFF_FFFF);
        bus_rd(5'h04, r); check("R6 write one no effect", r, 32'h16);
        bus_wr(5'h04, 32'h0);
        bus_rd(5'h04, r); check("R6 cleared by zero", r, 32'h06);

        // R9 loopback ignores rxd
        rxd = 1'b0;
        bus_wr(5'h00, 32'h96);
        wait_cycles(FRAME_WAIT);
        bus_rd(5'h00, r); check("R9 loopback byte", r, 32'h96);
        check("R9 txd carries frame", {24'h0, tx_last}, 32'h96);
        rxd = 1'b1;
        wait_cycles(4);

        // R11 reserved and undecoded offsets
        c0 = tx_count;
        bus_wr(5'h0C, 32'hFFFF_FFFF);
        bus_wr(5'h10, 32'hFFFF_FFFF);
        bus_wr(5'h14, 32'hFFFF_FFFF);
        bus_rd(5'h08, r); check("R11 control unchanged", r, 32'h83);
        bus_rd(5'h0C, r); check("R11 read 0x0C", r, 32'h0);
        bus_rd(5'h10, r); check("R11 read 0x10", r, 32'h0);
        bus_rd(5'h04, r); check("R11 status unchanged", r, 32'h06);
        wait_cycles(FRAME_WAIT);
        check("R11 nothing sent", tx_count, c0);

        // R8 receiver disabled
        bus_wr(5'h08, 32'h00);
        send_rx(8'h3C, 1'b1);
        bus_rd(5'h04, r); check("R8 ignored", r, 32'h06);
        bus_wr(5'h08, 32'h01);
        send_rx(8'h3C, 1'b1);
        bus_rd(5'h04, r); check("R8 enabled ready", r, 32'h07);
        bus_rd(5'h00, r); check("R4 pin byte", r, 32'h3C);

        // R7 framing error and break
        send_rx(8'hA5, 1'b0);
        bus_rd(5'h04, r); check("R7 framing", r, 32'h47);
        bus_rd(5'h00, r); check("R7 framing byte", r, 32'hA5);
        bus_rd(5'h04, r); check("R7 framing cleared", r, 32'h06);
        send_rx(8'h00, 1'b0);
        bus_rd(5'h04, r); check("R7 break", r, 32'h4F);
        bus_rd(5'h00, r);
        bus_rd(5'h04, r); check("R7 break cleared", r, 32'h06);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule